// File: doc/BRIEF.md
# Tile Max-Pool and Padding Stage

This block rebuilds one output tile of a feature map from a stream of input tiles. Each cycle it can take one 16-value input tile together with one instruction word. Four reduction units each pick any subset of the 16 input values and return the largest value in that subset. Sixteen output lanes then each choose one of the four reduction results, or they keep the value they already hold. The lanes update a registered 16-value output tile.

Max-pooling and padding both use this one datapath. For 2x2 pooling with stride 2, each reduction unit is given one quadrant of the input tile. Padding gives a unit a single input value, which then passes through unchanged. An empty subset produces a zero, which is how zero padding is inserted. Because a lane can keep its value, several instructions can each write part of the tile. This lets a larger region or another stride be assembled over several cycles. A synchronous clear returns the output tile to zero before a new tile is assembled.

Top module: `tile_poolpad`

## Requirements
- R1: After reset every output value is 8'h00 and `out_valid_o` is low.
- R2: `in_ready_o` is high whenever `clear_i` is low and low whenever `clear_i` is high, so an instruction is accepted exactly when `in_valid_i && in_ready_o`.
- R3: `out_valid_o` is high in the cycle after an accepted instruction and low in the cycle after any cycle with no acceptance.
- R4: Output lane p is selected by `sel_i[3p+2:3p]`. Code 0 keeps the lane's value. Code k in 1..4 loads the result of reduction unit k-1. Codes 5..7 also keep the value.
- R5: Values are sign-magnitude: bit 7 is the sign and bits 6:0 are the magnitude. Input value p is `tile_i[8p+7:8p]`. A reduction returns the largest value in its subset by signed value. Negative zero counts as equal to zero, and a zero result is always encoded as 8'h00, so 8'h80 never appears at the output.
- R6: When unit k's mask `mask_i[16k+15:16k]` has exactly one bit p set, the unit returns input p unchanged. The one exception is 8'h80, which comes out as 8'h00.
- R7: A unit whose mask is all zero returns 8'h00.
- R8: `clear_i` sets every output value to 8'h00 at the next edge. It takes priority over any instruction presented in the same cycle.
- R9: Quadrant masks 16'h0033, 16'h00CC, 16'h3300 and 16'hCC00, with codes 1..4 on lanes 0..3, give 2x2 stride-2 max-pooling of a row-major 4x4 tile.
- R10: Lanes that are kept retain the values written by earlier instructions, so successive instructions can fill different parts of one tile.
- R11: In a cycle with no accepted instruction and no clear, the output tile does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of the output tile |
| in_valid_i | input | 1 | Instruction and tile present |
| in_ready_o | output | 1 | Instruction can be accepted |
| tile_i | input | 128 | Input tile, 16 sign-magnitude values |
| mask_i | input | 64 | Four 16-bit subset masks, one per reduction unit |
| sel_i | input | 48 | Sixteen 3-bit lane select codes |
| out_valid_o | output | 1 | An instruction was applied at the previous edge |
| out_tile_o | output | 128 | Registered output tile |

## Verification
The hardest situation to reach is a lane keeping a value written several instructions earlier while other lanes are rewritten, with negative values and negative zero competing for the maximum. The stimulus chains a pooling instruction, a partial overwrite and a padding instruction, then uses the unused select codes. It follows this with back-to-back random instructions that mix many keep codes, so a lane's value ages over many accepts. A scoreboard keeps its own copy of the tile for every accepted instruction. A clear presented together with a valid instruction checks the priority rule.

// File: rtl/tile_poolpad_pkg.sv
package tile_poolpad_pkg;
  localparam int unsigned VAL_W_DEF = 8;
  localparam int unsigned N_POS_DEF = 16;
  localparam int unsigned N_MAX_DEF = 4;

  function automatic int unsigned sel_width(int unsigned n_max);
    return $clog2(n_max + 1);
  endfunction
endpackage

// File: rtl/poolpad_max_unit.sv
module poolpad_max_unit #(
  parameter int unsigned VAL_W = 8,
  parameter int unsigned N_POS = 16
) (
  input  logic [N_POS*VAL_W-1:0] tile_i,
  input  logic [N_POS-1:0]       mask_i,
  output logic [VAL_W-1:0]       max_o
);
  logic signed [VAL_W:0] best;
  logic signed [VAL_W:0] cur;
  logic signed [VAL_W:0] neg;
  logic [VAL_W:0]        mag;
  logic                  found;

  always_comb begin
    best  = '0;
    found = 1'b0;
    cur   = '0;
    mag   = '0;
    for (int i = 0; i < int'(N_POS); i++) begin
      mag = {2'b00, tile_i[i*VAL_W +: VAL_W-1]};
      cur = tile_i[i*VAL_W + VAL_W-1] ? -signed'(mag) : signed'(mag);
      if (mask_i[i] && (!found || cur > best)) begin
        best  = cur;
        found = 1'b1;
      end
    end
    if (!found) best = '0;
    neg = -best;
    // canonical encoding: zero is always positive
    if (best < 0) max_o = {1'b1, neg[VAL_W-2:0]};
    else          max_o = {1'b0, best[VAL_W-2:0]};
  end
endmodule

// File: rtl/poolpad_out_lane.sv
module poolpad_out_lane #(
  parameter int unsigned VAL_W = 8,
  parameter int unsigned N_MAX = 4,
  parameter int unsigned SEL_W = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clear_i,
  input  logic                   load_i,
  input  logic [SEL_W-1:0]       sel_i,
  input  logic [N_MAX*VAL_W-1:0] max_i,
  output logic [VAL_W-1:0]       val_o
);
  logic [VAL_W-1:0] val_q, val_d;

  always_comb begin
    val_d = val_q;
    for (int k = 0; k < int'(N_MAX); k++) begin
      if (sel_i == SEL_W'(k + 1)) val_d = max_i[k*VAL_W +: VAL_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      val_q <= '0;
    else if (clear_i) val_q <= '0;
    else if (load_i)  val_q <= val_d;
  end

  assign val_o = val_q;
endmodule

// File: rtl/tile_poolpad.sv
module tile_poolpad
  import tile_poolpad_pkg::*;
#(
  parameter int unsigned VAL_W = VAL_W_DEF,
  parameter int unsigned N_POS = N_POS_DEF,
  parameter int unsigned N_MAX = N_MAX_DEF,
  parameter int unsigned SEL_W = sel_width(N_MAX)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clear_i,
  input  logic                   in_valid_i,
  output logic                   in_ready_o,
  input  logic [N_POS*VAL_W-1:0] tile_i,
  input  logic [N_MAX*N_POS-1:0] mask_i,
  input  logic [N_POS*SEL_W-1:0] sel_i,
  output logic                   out_valid_o,
  output logic [N_POS*VAL_W-1:0] out_tile_o
);
  logic                   accept;
  logic [N_MAX*VAL_W-1:0] max_res;
  logic                   valid_q;

  assign in_ready_o = !clear_i;
  assign accept     = in_valid_i && in_ready_o;

  for (genvar k = 0; k < int'(N_MAX); k++) begin : g_max
    poolpad_max_unit #(.VAL_W(VAL_W), .N_POS(N_POS)) u_max (
      .tile_i (tile_i),
      .mask_i (mask_i[k*N_POS +: N_POS]),
      .max_o  (max_res[k*VAL_W +: VAL_W])
    );
  end

  for (genvar p = 0; p < int'(N_POS); p++) begin : g_lane
    poolpad_out_lane #(.VAL_W(VAL_W), .N_MAX(N_MAX), .SEL_W(SEL_W)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (clear_i),
      .load_i  (accept),
      .sel_i   (sel_i[p*SEL_W +: SEL_W]),
      .max_i   (max_res),
      .val_o   (out_tile_o[p*VAL_W +: VAL_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= accept;
  end

  assign out_valid_o = valid_q;
endmodule

// File: rtl/tile_poolpad_chk.sv
module tile_poolpad_chk #(
  parameter int unsigned VAL_W = 8,
  parameter int unsigned N_POS = 16,
  parameter int unsigned N_MAX = 4,
  parameter int unsigned SEL_W = 3
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   clear_i,
  input logic                   in_valid_i,
  input logic                   in_ready_o,
  input logic [N_POS*VAL_W-1:0] tile_i,
  input logic [N_MAX*N_POS-1:0] mask_i,
  input logic [N_POS*SEL_W-1:0] sel_i,
  input logic                   out_valid_o,
  input logic [N_POS*VAL_W-1:0] out_tile_o
);
  logic neg_zero_seen;

  always_comb begin
    neg_zero_seen = 1'b0;
    for (int p = 0; p < int'(N_POS); p++)
      if (out_tile_o[p*VAL_W +: VAL_W] == {1'b1, {(VAL_W-1){1'b0}}}) neg_zero_seen = 1'b1;
  end

  AST_READY_VS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o != clear_i); // R2
  AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o); // R3
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_ready_o) |=> !out_valid_o); // R3
  AST_CLEAR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (out_tile_o == '0)); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !in_valid_i) |=> $stable(out_tile_o)); // R11
  AST_NO_NEG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !neg_zero_seen); // R5
endmodule

bind tile_poolpad tile_poolpad_chk #(
  .VAL_W(VAL_W), .N_POS(N_POS), .N_MAX(N_MAX), .SEL_W(SEL_W)
) u_chk (.*);

// File: tb/tile_poolpad_bench.sv
module tile_poolpad_bench;
  localparam int VW = 8;
  localparam int NP = 16;
  localparam int NM = 4;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             clear, in_valid;
  logic [NP*VW-1:0] tile;
  logic [NM*NP-1:0] masks;
  logic [NP*SW-1:0] sels;
  logic             in_ready, out_valid;
  logic [NP*VW-1:0] out_tile;

  tile_poolpad u_tile_poolpad (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .in_valid_i(in_valid),
    .in_ready_o(in_ready), .tile_i(tile), .mask_i(masks), .sel_i(sels),
    .out_valid_o(out_valid), .out_tile_o(out_tile)
  );

  int checks = 0;
  int fails = 0;
  logic [NP*VW-1:0] exp_tile = '0;
  logic [NP*VW-1:0] exp_q[$];
  string            tag_q[$];

  task automatic chk(bit ok, string req, logic [NP*VW-1:0] act, logic [NP*VW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int to_i(logic [VW-1:0] v);
    return v[VW-1] ? -int'(v[VW-2:0]) : int'(v[VW-2:0]);
  endfunction

  function automatic logic [VW-1:0] from_i(int x);
    int m;
    m = (x < 0) ? -x : x;
    return (x < 0) ? {1'b1, m[VW-2:0]} : {1'b0, m[VW-2:0]};
  endfunction

  function automatic logic [VW-1:0] model_max(logic [NP*VW-1:0] t, logic [NP-1:0] m);
    int best = 0;
    bit f = 0;
    for (int i = 0; i < NP; i++)
      if (m[i] && (!f || to_i(t[i*VW +: VW]) > best)) begin
        best = to_i(t[i*VW +: VW]);
        f = 1;
      end
    return f ? from_i(best) : '0;
  endfunction

  function automatic logic [NP*SW-1:0] setsel(logic [NP*SW-1:0] s, int p, int c);
    s[p*SW +: SW] = SW'(c);
    return s;
  endfunction

  function automatic logic [NP*VW-1:0] mk_tile(logic [VW-1:0] v[NP]);
    logic [NP*VW-1:0] t;
    for (int i = 0; i < NP; i++) t[i*VW +: VW] = v[i];
    return t;
  endfunction

  task automatic send(logic [NP*VW-1:0] t, logic [NM*NP-1:0] m, logic [NP*SW-1:0] s, string tag);
    logic [VW-1:0] mx[NM];
    int c;
    @(negedge clk);
    tile = t; masks = m; sels = s; in_valid = 1'b1; clear = 1'b0;
    for (int k = 0; k < NM; k++) mx[k] = model_max(t, m[k*NP +: NP]);
    for (int p = 0; p < NP; p++) begin
      c = int'(s[p*SW +: SW]);
      if (c >= 1 && c <= NM) exp_tile[p*VW +: VW] = mx[c-1];
    end
    exp_q.push_back(exp_tile);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected out_valid", '0, '0);
      else begin
        logic [NP*VW-1:0] e;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        chk(out_tile == e, tg, out_tile, e);
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog expired act=%0d exp=%0d", checks, 0);
    summary();
    $finish;
  end

  initial begin
    logic [VW-1:0] v[NP];
    logic [NP*SW-1:0] s;
    logic [NP*VW-1:0] hold;
    clear = 1'b0; in_valid = 1'b0; tile = '0; masks = '0; sels = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_tile == '0, "R1 reset tile", out_tile, '0);
    chk(out_valid == 1'b0, "R1 reset valid", {127'd0, out_valid}, '0);
    chk(in_ready == 1'b1, "R2 ready without clear", {127'd0, in_ready}, 128'd1);

    // R9 quadrant pooling, negatives and negative zero (R5)
    v = '{8'h05, 8'h83, 8'h09, 8'h02, 8'h87, 8'h04, 8'h01, 8'h8A,
          8'h90, 8'h85, 8'h81, 8'h82, 8'h95, 8'h80, 8'h88, 8'h84};
    s = '0;
    for (int p = 0; p < 4; p++) s = setsel(s, p, p + 1);
    send(mk_tile(v), {16'hCC00, 16'h3300, 16'h00CC, 16'h0033}, s, "R9 2x2 pool");

    // R10 second quadrant set into lanes 4..7, lanes 0..3 kept
    v = '{8'h11, 8'h22, 8'h83, 8'h84, 8'h33, 8'h7F, 8'h85, 8'h86,
          8'hFF, 8'hFE, 8'h00, 8'h80, 8'h8F, 8'h8E, 8'h80, 8'h80};
    s = '0;
    for (int p = 4; p < 8; p++) s = setsel(s, p, p - 3);
    send(mk_tile(v), {16'hCC00, 16'h3300, 16'h00CC, 16'h0033}, s, "R10 partial fill");

    // R6/R7 padding: single-element masks and an empty mask
    v = '{8'h9A, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h6C, 8'h07,
          8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h80, 8'h0E, 8'h0F};
    s = '0;
    for (int p = 8; p < 16; p++) s = setsel(s, p, (p % 4) + 1);
    send(mk_tile(v), {16'h0001, 16'h2000, 16'h0000, 16'h0040}, s, "R6 R7 pad");

    // R5 all-negative subset gives least negative value
    v = '{8'hA0, 8'h8F, 8'hC4, 8'hFF, 8'h81, 8'h90, 8'h91, 8'h92,
          8'h93, 8'h94, 8'h95, 8'h96, 8'h97, 8'h98, 8'h99, 8'h9A};
    s = setsel('0, 0, 1);
    send(mk_tile(v), {16'h0000, 16'h0000, 16'h0000, 16'h001F}, s, "R5 negatives");

    // R4 codes 5..7 keep the lane
    s = '0;
    for (int p = 0; p < 16; p++) s = setsel(s, p, 5 + (p % 3));
    send('1, '1, s, "R4 unused codes hold");

    // R3 back-to-back random stream
    for (int n = 0; n < 60; n++)
      send({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom},
           {$urandom, $urandom}, "R3 R4 back-to-back");
    idle();
    hold = exp_tile;
    @(negedge clk);
    chk(out_tile == hold, "R11 idle keeps tile", out_tile, hold);
    chk(out_valid == 1'b0, "R3 no valid when idle", {127'd0, out_valid}, '0);

    // R8 clear with a competing instruction
    @(negedge clk);
    clear = 1'b1; in_valid = 1'b1; masks = '1; tile = '1;
    sels = '0; for (int p = 0; p < 16; p++) sels = setsel(sels, p, 1);
    #1 chk(in_ready == 1'b0, "R2 ready low in clear", {127'd0, in_ready}, '0);
    @(negedge clk);
    clear = 1'b0; in_valid = 1'b0;
    chk(out_tile == '0, "R8 clear zeroes tile", out_tile, '0);
    chk(out_valid == 1'b0, "R8 clear not accepted", {127'd0, out_valid}, '0);
    exp_tile = '0;

    // R10 refill after clear: only lane 3 written
    v = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
          8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h42};
    send(mk_tile(v), {48'd0, 16'h8000}, setsel('0, 3, 1), "R10 refill after clear");
    idle();
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all results seen", 128'(exp_q.size()), '0);
    summary();
    $finish;
  end
endmodule